// File: doc/BRIEF.md
# Serial ADC Host Interface Controller

This block is the host side of a link to a two-channel, 12-bit successive-approximation converter that has a serial output. A one-cycle start request latches five request inputs: channel, input mode, result bit order, power-down request and wiring mode. The block then pulls chip select low and derives a serial clock from the system clock. It shifts a start bit and a four-bit configuration word out to the converter, discards the null bit the converter returns, and shifts in the twelve result bits. It then returns the result as a plain binary word with a one-cycle done pulse.

The serial clock idles low. Each bit the controller sends changes on a falling edge of the serial clock. Each bit it receives is sampled on a rising edge. A frame is always eighteen serial clock periods long. The converter pads with zeros after the last result bit, and the controller ignores that padding. The controller can run over four wires, with separate data lines for each direction. It can also run over three wires, where one shared data pin carries both directions and the controller releases the pin once its configuration word has been sent.

Top module: `adc_link_ctrl`

## Requirements
- R1: After reset, and whenever no frame is running, chip select is high, the serial clock is low, the data-pin enable is low, done is low and busy is low.
- R2: A start request is accepted only while idle. Chip select falls on the next cycle, and in that same cycle the data pin is enabled and driven with the start bit, value 1. A start request during a frame is ignored, and the request inputs are only latched at acceptance.
- R3: Every high phase and every low phase of the serial clock lasts SCLK_HALF system clock cycles. A frame has exactly 18 rising serial clock edges.
- R4: The start bit is followed by four configuration bits, sent in this order: input mode (1 = single-ended, 0 = differential), channel select / sign (odd channel = 1), bit order (1 = most significant first), power-down request. The outgoing data bit changes only while the serial clock is low.
- R5: The bit sampled on the 6th rising edge is the null bit. Its value has no effect on the result.
- R6: With bit order 1, rising edges 7 to 18 carry result bits 11 down to 0.
- R7: With bit order 0, rising edges 7 to 18 carry result bits 0 up to 11, and the reassembled word on result_o is in normal binary order.
- R8: In three-wire mode (three_wire_i = 1 at start), result bits are sampled from sd_i. The pin enable drops at the falling edge after the 5th rising edge and stays low for the rest of the frame. In four-wire mode, bits are sampled from so_i and the enable stays high for the whole frame.
- R9: done_o is a one-cycle pulse in the same cycle that chip select rises, exactly 36*SCLK_HALF cycles after the accepting clock edge. result_o holds its value until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| single_ended_i | input | 1 | 1 = single-ended input mode, 0 = differential |
| odd_chan_i | input | 1 | Channel select / sign bit |
| msb_first_i | input | 1 | 1 = result arrives most significant bit first |
| power_down_i | input | 1 | Request converter power-down after conversion |
| three_wire_i | input | 1 | 1 = shared data pin for both directions |
| busy_o | output | 1 | Frame in progress |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| sd_o | output | 1 | Data toward the converter |
| sd_oe_o | output | 1 | Output enable for the data pin |
| sd_i | input | 1 | Shared data pin readback, used in three-wire mode |
| so_i | input | 1 | Converter data line, used in four-wire mode |
| result_o | output | 12 | Last conversion result, binary order |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The start bit and chip select fall are due one cycle after the accepting edge, so the driver checks them at the next falling system clock edge. The converter model answers each serial clock edge: it collects five bits by the 5th rising edge, drives the null bit as 1 on purpose, and drives result bits on the following falling edges, which leaves the controller SCLK_HALF cycles of setup before each sample. The done pulse is due 36*SCLK_HALF cycles after acceptance. The scoreboard stores the cycle number of each accepted start with its expected word and compares the exact distance when done appears.

// File: rtl/adc_link_pkg.sv
package adc_link_pkg;

    localparam int RES_W          = 12;
    localparam int CFG_W          = 4;
    localparam int CFG_LAST_RISE  = CFG_W + 1;
    localparam int NULL_RISE      = CFG_LAST_RISE + 1;
    localparam int FRAME_RISES    = NULL_RISE + RES_W;
    localparam int RISE_W         = $clog2(FRAME_RISES + 1);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } link_state_e;

    typedef struct packed {
        link_state_e         st;
        logic                cs_n;
        logic                sclk;
        logic                sd;
        logic                oe;
        logic                tw;
        logic                msbf;
        logic                done;
        logic [CFG_W-1:0]    cfg;
        logic [RISE_W-1:0]   rises;
        logic [RES_W-1:0]    shreg;
        logic [RES_W-1:0]    result;
    } link_ctrl_t;

endpackage

// File: rtl/adc_link_tick.sv
module adc_link_tick #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CNT_W = $clog2(HALF) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = en_i && (cnt_q == LAST);
        if (!en_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_link_order.sv
module adc_link_order #(
    parameter int W = 12
) (
    input  logic [W-1:0] raw_i,
    input  logic         msb_first_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] rev;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev[i] = raw_i[W-1-i];
    end

    assign word_o = msb_first_i ? raw_i : rev;
endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
    import adc_link_pkg::*;
#(
    parameter int SCLK_HALF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             single_ended_i,
    input  logic             odd_chan_i,
    input  logic             msb_first_i,
    input  logic             power_down_i,
    input  logic             three_wire_i,
    output logic             busy_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             sd_o,
    output logic             sd_oe_o,
    input  logic             sd_i,
    input  logic             so_i,
    output logic [RES_W-1:0] result_o,
    output logic             done_o
);
    localparam logic [RISE_W-1:0] CFG_END_R = RISE_W'(CFG_LAST_RISE);
    localparam logic [RISE_W-1:0] NULL_R    = RISE_W'(NULL_RISE);
    localparam logic [RISE_W-1:0] FRAME_R   = RISE_W'(FRAME_RISES);

    link_ctrl_t        d, q;
    logic              tick;
    logic              rx_bit;
    logic [RISE_W-1:0] next_rise;
    logic [RES_W-1:0]  fmt_word;

    adc_link_tick #(.HALF(SCLK_HALF)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (q.st == ST_RUN),
        .tick_o (tick)
    );

    adc_link_order #(.W(RES_W)) i_order (
        .raw_i       (q.shreg),
        .msb_first_i (q.msbf),
        .word_o      (fmt_word)
    );

    assign rx_bit    = q.tw ? sd_i : so_i;
    assign next_rise = q.rises + 1'b1;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_RUN;
                    d.cs_n  = 1'b0;
                    d.sclk  = 1'b0;
                    d.sd    = 1'b1;
                    d.oe    = 1'b1;
                    d.tw    = three_wire_i;
                    d.msbf  = msb_first_i;
                    d.cfg   = {single_ended_i, odd_chan_i, msb_first_i, power_down_i};
                    d.rises = '0;
                    d.shreg = '0;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk  = 1'b1;
                        d.rises = next_rise;
                        if (next_rise > NULL_R) begin
                            d.shreg = {q.shreg[RES_W-2:0], rx_bit};
                        end
                    end else if (q.rises == FRAME_R) begin
                        d.st     = ST_IDLE;
                        d.cs_n   = 1'b1;
                        d.sclk   = 1'b0;
                        d.sd     = 1'b0;
                        d.oe     = 1'b0;
                        d.done   = 1'b1;
                        d.result = fmt_word;
                    end else begin
                        d.sclk = 1'b0;
                        if (q.rises < CFG_END_R) begin
                            d.sd  = q.cfg[CFG_W-1];
                            d.cfg = {q.cfg[CFG_W-2:0], 1'b0};
                        end else begin
                            d.sd = 1'b0;
                            if (q.tw) begin
                                d.oe = 1'b0;
                            end
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.st == ST_RUN);
    assign cs_n_o   = q.cs_n;
    assign sclk_o   = q.sclk;
    assign sd_o     = q.sd;
    assign sd_oe_o  = q.oe;
    assign result_o = q.result;
    assign done_o   = q.done;
endmodule

// File: rtl/adc_link_chk.sv
module adc_link_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic cs_n_o,
    input logic sclk_o,
    input logic sd_o,
    input logic sd_oe_o,
    input logic done_o
);
    a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    a_r1_pin_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sd_oe_o);

    a_r2_start_bit_at_select: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (sd_o && sd_oe_o));

    a_r2_accept_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> ($past(start_i) && !$past(busy_o)));

    a_r4_launch_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_o) |-> !sclk_o);

    a_r8_no_regrab: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && !$past(cs_n_o) && !$past(sd_oe_o)) |-> !sd_oe_o);

    a_r9_done_with_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(cs_n_o));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind adc_link_ctrl adc_link_chk i_adc_link_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .sd_o    (sd_o),
    .sd_oe_o (sd_oe_o),
    .done_o  (done_o)
);

// File: tb/test_adc_link_ctrl.sv
`timescale 1ns/1ps
module test_adc_link_ctrl;
    localparam int HALF    = 3;
    localparam int LAT     = 36 * HALF + 1;
    localparam int PERIOD  = 2 * HALF * 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        single_ended_i = 1'b0, odd_chan_i = 1'b0, msb_first_i = 1'b0;
    logic        power_down_i = 1'b0, three_wire_i = 1'b0;
    logic        busy_o, cs_n_o, sclk_o, sd_o, sd_oe_o, sd_i, so_i, done_o;
    logic [11:0] result_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [11:0] exp_q[$];
    int          t_q[$];
    string       tag_q[$];

    // converter model state
    logic [11:0] m_val = '0;
    logic        m_msbf = 1'b1, m_tw = 1'b0, m_out = 1'b0, m_active = 1'b0;
    logic        m_per_bad = 1'b0, m_oe_bad = 1'b0;
    logic [4:0]  m_exp5 = '0, m_cfg = '0;
    int          m_rise = 0, m_fall = 0;
    time         t_last = 0;
    logic        line;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign line = sd_oe_o ? sd_o : m_out;
    assign sd_i = m_tw ? line : sd_o;
    assign so_i = m_tw ? 1'b1 : m_out;

    adc_link_ctrl #(.SCLK_HALF(HALF)) i_adc_link_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .single_ended_i(single_ended_i), .odd_chan_i(odd_chan_i),
        .msb_first_i(msb_first_i), .power_down_i(power_down_i),
        .three_wire_i(three_wire_i), .busy_o(busy_o), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o), .sd_i(sd_i),
        .so_i(so_i), .result_o(result_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // behavioural converter
    always @(posedge sclk_o or negedge sclk_o or posedge cs_n_o) begin
        if (cs_n_o !== 1'b0) begin
            if (m_active) begin
                chk(m_rise == 18, "R3 rising edges per frame", m_rise, 18);
                chk(!m_per_bad, "R3 serial clock period", m_per_bad, 0);
                chk(!m_oe_bad, "R8 pin enable timing", m_oe_bad, 0);
                m_active = 1'b0;
            end
            m_rise = 0; m_fall = 0; m_out = 1'b0;
            m_per_bad = 1'b0; m_oe_bad = 1'b0;
        end else if (sclk_o) begin
            m_active = 1'b1;
            m_rise++;
            if (m_rise > 1 && ($time - t_last) != PERIOD) m_per_bad = 1'b1;
            t_last = $time;
            if (sd_oe_o !== (m_tw ? (m_rise <= 5) : 1'b1)) m_oe_bad = 1'b1;
            if (m_rise <= 5) m_cfg = {m_cfg[3:0], (sd_oe_o ? sd_o : 1'b0)};
            if (m_rise == 5)
                chk(m_cfg == m_exp5, "R4 start and config bits", m_cfg, m_exp5);
        end else begin
            m_fall++;
            if (m_fall == 5) m_out = 1'b1;              // null bit, deliberately one
            else if (m_fall >= 6 && m_fall <= 17)
                m_out = m_msbf ? m_val[11 - (m_fall - 6)] : m_val[m_fall - 6];
            else m_out = 1'b0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                automatic logic [11:0] e = exp_q.pop_front();
                automatic int          t = t_q.pop_front();
                automatic string       g = tag_q.pop_front();
                chk(result_o == e, {g, " R5 result word"}, result_o, e);
                chk(cyc - t == LAT, "R9 done latency", cyc - t, LAT);
                chk(cs_n_o == 1'b1, "R9 deselect with done", cs_n_o, 1);
            end
        end
    end

    logic [11:0] prev_res = '0;
    bit          have_prev = 0;

    task automatic run_frame(input logic [11:0] val, input logic se, input logic odd,
                             input logic msbf, input logic pd, input logic tw,
                             input bit poke, input string tag);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        if (have_prev) chk(result_o == prev_res, "R9 result held", result_o, prev_res);
        m_val = val; m_msbf = msbf; m_tw = tw; m_exp5 = {1'b1, se, odd, msbf, pd};
        single_ended_i = se; odd_chan_i = odd; msb_first_i = msbf;
        power_down_i = pd; three_wire_i = tw;
        exp_q.push_back(val); t_q.push_back(cyc); tag_q.push_back(tag);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(cs_n_o == 1'b0 && sd_o && sd_oe_o, "R2 select and start bit",
            {cs_n_o, sd_o, sd_oe_o}, 3'b011);
        if (poke) begin
            repeat (8) @(negedge clk);
            single_ended_i = ~se; odd_chan_i = ~odd; msb_first_i = ~msbf;
            power_down_i = ~pd; three_wire_i = ~tw;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        if (poke) begin
            repeat (5) @(negedge clk);
            chk(cs_n_o && !busy_o, "R2 start during frame ignored", {cs_n_o, busy_o}, 2'b10);
        end
        prev_res = val; have_prev = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({cs_n_o, sclk_o, sd_oe_o, done_o, busy_o} == 5'b10000, "R1 reset state",
            {cs_n_o, sclk_o, sd_oe_o, done_o, busy_o}, 5'b10000);
        run_frame(12'hA5C, 1, 0, 1, 0, 0, 0, "R6");
        run_frame(12'h3C7, 1, 1, 0, 0, 0, 0, "R7");
        run_frame(12'h800, 0, 0, 1, 0, 1, 0, "R8 R6");
        run_frame(12'h001, 0, 1, 0, 1, 1, 0, "R8 R7");
        run_frame(12'hFFF, 1, 0, 1, 1, 0, 1, "R2 R6");
        run_frame(12'h000, 1, 1, 1, 0, 1, 0, "R8 R6");
        run_frame(12'h6B1, 0, 0, 0, 0, 0, 0, "R7");
        repeat (10) @(negedge clk);
        chk({cs_n_o, sclk_o, sd_oe_o, done_o, busy_o} == 5'b10000, "R1 idle after frames",
            {cs_n_o, sclk_o, sd_oe_o, done_o, busy_o}, 5'b10000);
        chk(exp_q.size() == 0, "R9 one done per frame", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule